// File: doc/BRIEF.md
# Sobel Gradient Magnitude Pipeline

This block turns a 3x3 window of 24-bit colour pixels into one 8-bit edge-strength pixel. It is bit-exact fixed-point arithmetic. Each neighbour pixel is first reduced to a 12-bit luminance with small integer weights. Two Sobel sums are then formed, one per direction. Their squares are added, and the total is scaled, saturated and truncated to a 13-bit index. A per-index transfer function maps that index to an inverted, halved square root. The result is 255 (white) in flat regions and falls toward 0 (black) on strong edges.

The window comes from line and pixel delay stages outside this block, along with a valid strobe. The centre pixel has zero weight in both kernels, so only the eight neighbours are ports. One result is produced for every valid window. There are four register stages, and a window may be presented on every clock.

Top module: `edge_mag_pipe`

## Requirements
- R1: Each neighbour's luminance is Y = 5*R + 9*G + 2*B, where R = bits [23:16], G = bits [15:8] and B = bits [7:0] of the tap. Y lies in 0..4080.
- R2: The horizontal sum is (Y_ne + 2*Y_e + Y_se) - (Y_nw + 2*Y_w + Y_sw), i.e. the right column minus the left column.
- R3: The vertical sum is (Y_sw + 2*Y_s + Y_se) - (Y_nw + 2*Y_n + Y_ne), i.e. the bottom row minus the top row.
- R4: The two sums are squared and added. The total is divided by 256 with the remainder dropped. It is then saturated to 262143, and its 5 low bits are dropped, giving a 13-bit index a.
- R5: The output pixel is 255 - floor(floor(sqrt(32*a)) / 2), limited below at 0.
- R6: A window whose eight neighbours all have the same luminance gives 255.
- R7: Any window whose scaled square sum exceeds 262143 gives 0.
- R8: out_valid rises exactly 4 rising edges after in_valid is sampled high. Together with it, out_pix carries the result for the window sampled in that cycle. Back-to-back windows give back-to-back results.
- R9: out_pix keeps its last value in every cycle where out_valid is low.
- R10: While rst_n is low, out_valid is 0 and out_pix is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Window on the taps is valid this cycle |
| win_nw | input | 24 | Top-left tap, RGB |
| win_n | input | 24 | Top-middle tap, RGB |
| win_ne | input | 24 | Top-right tap, RGB |
| win_w | input | 24 | Middle-left tap, RGB |
| win_e | input | 24 | Middle-right tap, RGB |
| win_sw | input | 24 | Bottom-left tap, RGB |
| win_s | input | 24 | Bottom-middle tap, RGB |
| win_se | input | 24 | Bottom-right tap, RGB |
| out_valid | output | 1 | out_pix holds a new result |
| out_pix | output | 8 | Inverted edge strength, 255 = no edge |

## Verification
A window that is driven on a falling edge is captured at the next rising edge. Its result and its valid flag are due after the fourth rising edge following that capture. The bench keeps a four-entry shadow of the valid flags, expected pixels and requirement tags it has driven. At every falling edge it compares out_valid and out_pix against the entry that is leaving the shadow. When that entry is empty, the bench instead requires out_pix to equal the last result delivered. The gray-edge sweeps fall on both sides of the saturation point: a step of 127 is expected to give 2, and a step of 128 is expected to give 0.

// File: rtl/edge_mag_pipe.sv
module edge_mag_pipe #(
  parameter int CH_W    = 8,
  parameter int LUMA_W  = 12,
  parameter int WR      = 5,
  parameter int WG      = 9,
  parameter int WB      = 2,
  parameter int PRE_SHR = 8,
  parameter int SAT_W   = 18,
  parameter int ADDR_W  = 13,
  parameter int OUT_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [3*CH_W-1:0]    win_nw,
  input  logic [3*CH_W-1:0]    win_n,
  input  logic [3*CH_W-1:0]    win_ne,
  input  logic [3*CH_W-1:0]    win_w,
  input  logic [3*CH_W-1:0]    win_e,
  input  logic [3*CH_W-1:0]    win_sw,
  input  logic [3*CH_W-1:0]    win_s,
  input  logic [3*CH_W-1:0]    win_se,
  output logic                 out_valid,
  output logic [OUT_W-1:0]     out_pix
);
  localparam int PIX_W    = 3*CH_W;
  localparam int SUM_W    = LUMA_W + 3;
  localparam int SQ_W     = 2*SUM_W - 1;
  localparam int DROP     = SAT_W - ADDR_W;
  localparam int ROOT_W   = (SAT_W + 1) / 2;
  localparam int OUT_MAX  = 2**OUT_W - 1;
  localparam int LUMA_MAX = (WR + WG + WB) * (2**CH_W - 1);
  localparam logic [SQ_W-1:0] SAT_SQ = SQ_W'(1) << (SAT_W + PRE_SHR);

  function automatic logic [LUMA_W-1:0] luma(input logic [PIX_W-1:0] p);
    int s;
    s = WR*int'(p[3*CH_W-1:2*CH_W]) + WG*int'(p[2*CH_W-1:CH_W]) + WB*int'(p[CH_W-1:0]);
    return LUMA_W'(s);
  endfunction

  function automatic logic signed [SUM_W-1:0] kern(
    input logic [LUMA_W-1:0] pa, pb, pc, na, nb, nc);
    return SUM_W'((int'(pa) + 2*int'(pb) + int'(pc)) - (int'(na) + 2*int'(nb) + int'(nc)));
  endfunction

  function automatic logic [ROOT_W-1:0] isqrt(input logic [SAT_W-1:0] v);
    logic [ROOT_W-1:0] r, t;
    r = '0;
    for (int b = ROOT_W-1; b >= 0; b--) begin
      t = r | (ROOT_W'(1) << b);
      if (SAT_W'(t) * SAT_W'(t) <= v) r = t;
    end
    return r;
  endfunction

  logic [PIX_W-1:0]  tap [8];
  logic [LUMA_W-1:0] y_q [8];
  logic [3:0]        vpipe;
  logic signed [SUM_W-1:0]   gx_q, gy_q;
  logic signed [2*SUM_W-1:0] gx_e, gy_e, px, py;
  logic [SQ_W-1:0]   sq_c, sq_q, shr;
  logic [ADDR_W-1:0] addr;
  logic [ROOT_W-1:0] root;
  logic [OUT_W-1:0]  out_c;

  assign tap[0] = win_nw;
  assign tap[1] = win_n;
  assign tap[2] = win_ne;
  assign tap[3] = win_w;
  assign tap[4] = win_e;
  assign tap[5] = win_sw;
  assign tap[6] = win_s;
  assign tap[7] = win_se;

  assign out_valid = vpipe[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[2:0], in_valid};

  generate
    for (genvar i = 0; i < 8; i++) begin : g_luma
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) y_q[i] <= '0;
        else        y_q[i] <= luma(tap[i]);

      p_luma_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vpipe[0] |-> (int'(y_q[i]) <= LUMA_MAX));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gx_q <= '0;
      gy_q <= '0;
    end else begin
      gx_q <= kern(y_q[2], y_q[4], y_q[7], y_q[0], y_q[3], y_q[5]);
      gy_q <= kern(y_q[5], y_q[6], y_q[7], y_q[0], y_q[1], y_q[2]);
    end

  assign gx_e = {{SUM_W{gx_q[SUM_W-1]}}, gx_q};
  assign gy_e = {{SUM_W{gy_q[SUM_W-1]}}, gy_q};
  assign px   = gx_e * gx_e;
  assign py   = gy_e * gy_e;
  assign sq_c = SQ_W'(px + py);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sq_q <= '0;
    else        sq_q <= sq_c;

  assign shr  = sq_q >> (PRE_SHR + DROP);
  assign addr = (shr > SQ_W'(2**ADDR_W - 1)) ? '1 : shr[ADDR_W-1:0];
  assign root = isqrt({addr, {DROP{1'b0}}});

  always_comb begin
    int h;
    h = int'(root >> 1);
    out_c = (h > OUT_MAX) ? '0 : OUT_W'(OUT_MAX - h);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        out_pix <= '1;
    else if (vpipe[2]) out_pix <= out_c;

  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              warm <= '0;
    else if (warm != 3'd4)   warm <= warm + 3'd1;

  p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_pix));

  p_flat_white_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vpipe[1] && gx_q == '0 && gy_q == '0) |=> ##1 (out_pix == OUT_W'(OUT_MAX)));

  p_saturate_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vpipe[2] && sq_q >= SAT_SQ) |=> (out_pix == '0));

  p_sum_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vpipe[1] && gx_q == '0 && gy_q == '0) |=> (sq_q == '0));
endmodule

// File: tb/sim_edge_mag_pipe.sv
`timescale 1ns/1ps
module sim_edge_mag_pipe;
  logic clk = 1'b0;
  logic rst_n, in_valid;
  logic [8:0][23:0] win;
  logic out_valid;
  logic [7:0] out_pix;

  always #10 clk = ~clk;

  edge_mag_pipe u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .win_nw(win[0]), .win_n(win[1]), .win_ne(win[2]),
    .win_w(win[3]), .win_e(win[5]),
    .win_sw(win[6]), .win_s(win[7]), .win_se(win[8]),
    .out_valid(out_valid), .out_pix(out_pix));

  int n_chk = 0, n_bad = 0;
  logic vh [4];
  int eh [4];
  string th [4];
  int last_exp = 255;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int isq(input int v);
    int r = 0;
    while ((r+1)*(r+1) <= v) r++;
    return r;
  endfunction

  function automatic int model(input logic [8:0][23:0] w);
    int y [9];
    longint gx, gy, sq, s;
    int a, o;
    for (int i = 0; i < 9; i++)
      y[i] = 5*int'(w[i][23:16]) + 9*int'(w[i][15:8]) + 2*int'(w[i][7:0]);
    gx = (y[2] + 2*y[5] + y[8]) - (y[0] + 2*y[3] + y[6]);
    gy = (y[6] + 2*y[7] + y[8]) - (y[0] + 2*y[1] + y[2]);
    sq = gx*gx + gy*gy;
    s = sq / 256;
    if (s > 262143) s = 262143;
    a = int'(s / 32);
    o = 255 - isq(a*32) / 2;
    return (o < 0) ? 0 : o;
  endfunction

  function automatic logic [8:0][23:0] cols(input logic [23:0] l, m, r);
    logic [8:0][23:0] w;
    for (int k = 0; k < 3; k++) begin
      w[3*k] = l; w[3*k+1] = m; w[3*k+2] = r;
    end
    return w;
  endfunction

  function automatic logic [8:0][23:0] rows(input logic [23:0] t, m, b);
    logic [8:0][23:0] w;
    for (int k = 0; k < 3; k++) begin
      w[k] = t; w[3+k] = m; w[6+k] = b;
    end
    return w;
  endfunction

  function automatic logic [23:0] gray(input int g);
    return {g[7:0], g[7:0], g[7:0]};
  endfunction

  task automatic step(input logic v, input logic [8:0][23:0] w, input int e, input string tag);
    @(negedge clk);
    chk("R8 valid", int'(out_valid), int'(vh[3]));
    if (vh[3]) begin
      chk(th[3], int'(out_pix), eh[3]);
      last_exp = eh[3];
    end else begin
      chk("R9 hold", int'(out_pix), last_exp);
    end
    for (int i = 3; i > 0; i--) begin
      vh[i] = vh[i-1]; eh[i] = eh[i-1]; th[i] = th[i-1];
    end
    vh[0] = v; eh[0] = e; th[0] = tag;
    in_valid = v;
    win = w;
  endtask

  task automatic push(input logic [8:0][23:0] w, input string tag);
    step(1'b1, w, model(w), tag);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8:0][23:0] w;
    for (int i = 0; i < 4; i++) begin vh[i] = 1'b0; eh[i] = 0; th[i] = ""; end
    rst_n = 1'b0; in_valid = 1'b0; win = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", int'(out_valid), 0);
    chk("R10 reset pix", int'(out_pix), 255);
    rst_n = 1'b1;

    for (int g = 0; g < 256; g += 17) push(cols(gray(g), gray(g), gray(g)), "R6 flat");
    push(cols(24'h3C80F0, 24'h3C80F0, 24'h3C80F0), "R6 flat colour");
    step(1'b1, cols(0, 0, gray(10)), 235, "R5 step10");
    step(1'b1, cols(0, 0, gray(127)), 2, "R4 step127");
    step(1'b1, cols(0, 0, gray(128)), 0, "R7 step128");
    step(1'b1, cols(0, 0, 24'hFFFFFF), 0, "R7 max horiz");
    step(1'b1, rows(24'hFFFFFF, 0, 0), 0, "R7 max vert");

    for (int k = 0; k < 256; k++) begin
      push(cols(0, 0, {k[7:0], 16'h0}), "R1 red");
      push(cols(0, 0, {8'h0, k[7:0], 8'h0}), "R1 green");
      push(rows(0, 0, {16'h0, k[7:0]}), "R1 blue");
    end
    for (int g = 0; g < 256; g++) begin
      push(cols(gray(g), 0, 0), "R2 left edge");
      push(rows(0, gray(g), gray(g)), "R3 bottom edge");
    end
    for (int g = 0; g < 256; g += 3) begin
      w = '0; w[2] = gray(g); w[5] = gray(g / 2); w[7] = gray(g);
      push(w, "R4 diagonal");
    end

    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < 9; i++) begin
        if (n % 3 == 0) w[i] = 24'($urandom);
        else w[i] = {8'(60 + $urandom_range(0, 20)), 8'(90 + $urandom_range(0, 20)),
                     8'(30 + $urandom_range(0, 20))};
      end
      if ($urandom_range(0, 3) == 0) step(1'b0, w, 0, "R9 idle");
      else push(w, "R5 random");
    end

    repeat (6) step(1'b0, '0, 0, "R9 drain");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule